// File: doc/BRIEF.md
# SPI Command-Framed Buffer Target

This block is an SPI target placed in programmable logic and driven by a host microcontroller. The host opens a frame by pulling chip select low. The first byte of every frame is a command. The target then follows a fixed byte layout for that command. It can return a fixed identification byte, load or return a 16-bit length register, load or return an 8-bit state register, fill an internal byte buffer, or stream that buffer back out.

All three SPI inputs are oversampled in the system clock domain. A synchronizer with edge detection feeds a byte shifter, and an enumerated state machine sets the meaning of each byte. The machine has ten states: IDLE, CMD, ID, WLEN, WSTATE, WDATA, RLEN, RSTATE, RDATA and IGNORE. It has three kinds of transition:
- IDLE to CMD when chip select becomes active.
- CMD to one of ID, WLEN, WSTATE, WDATA, RLEN, RSTATE, RDATA or IGNORE when the command byte completes, chosen by its value.
- Any state to IDLE when chip select goes inactive.

The reply byte for position k+1 is chosen when byte k completes. The shifter holds that reply before the first falling SCLK edge of the next byte.

Top module: `spi_cmdbuf`

## Requirements
- R1: SPI mode 3, 8-bit words, most significant bit first. The target samples MOSI on rising SCLK and updates MISO only after falling SCLK, so the first bit of each reply byte appears after the byte's first falling edge. Each SCLK level lasts at least 4 system clock cycles.
- R2: Byte 0 of every frame is decoded as a command: 0x01 identify, 0x02 load length, 0x03 load state, 0x04 write buffer, 0x05 return length, 0x06 return state, 0x07 read buffer.
- R3: In an identify frame, MISO carries ID_VALUE (default 0x01) during byte 4, and 0x00 during bytes 0 to 3.
- R4: In a write-buffer frame, bytes 1 and 2 are ignored. Byte 3+i is stored at buffer address i, for i from 0 to DEPTH-1 (DEPTH defaults to 1024).
- R5: In a read-buffer frame, MISO is 0x00 during bytes 0 to 3 (byte 3 is a dummy). During byte 4+i it carries buffer address i, for i from 0 to DEPTH-1.
- R6: With WRAP_EN=0, payload bytes past DEPTH are dropped, so the trailing pseudo byte never overwrites address 0. With WRAP_EN=1, the write address wraps to 0 after DEPTH-1.
- R7: Command 0x02 loads the length register: byte 1 is the high byte and byte 2 the low byte. Command 0x05 returns the high byte at byte 4 and the low byte at byte 5. The register resets to 0x0000.
- R8: Command 0x03 loads the state register from byte 1. Command 0x06 returns it at byte 4. The register resets to 0x00.
- R9: Raising chip select ends the frame at once. A partly shifted byte is discarded, the byte and bit counters restart, and the next frame begins with a command byte.
- R10: MISO is 0 while chip select is high and after reset.
- R11: Any other command byte makes the target ignore the rest of the frame. MISO stays 0 and no register or buffer changes.
- R12: Consecutive frames separated by chip select high for only 3 system clock cycles are all decoded and applied without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCLK rate |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| spi_sclk | input | 1 | SPI clock from host, idles high |
| spi_cs_n | input | 1 | Active-low chip select framing each transfer |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data, 0 when not selected |

## Verification
The assertions assume a well-behaved SPI host:
- SCLK is high whenever chip select changes.
- MOSI changes only near falling SCLK edges.
- Each SCLK level is held long enough that a completed byte's reply is loaded before the next falling edge, so a reply load and a shift never coincide.

The bench meets these assumptions with one serial task. That task toggles SCLK only at falling system clock edges and holds each level for four cycles. It also keeps chip select low for four cycles around the SCLK activity. The only places the bench leaves normal framing are the deliberately aborted frames, which raise chip select while SCLK is high.

// File: rtl/spi_cmdbuf_pkg.sv
package spi_cmdbuf_pkg;

    localparam int BYTE_W     = 8;
    localparam int WR_HDR_LEN = 3;   // command + two ignored bytes
    localparam int RD_HDR_LEN = 4;   // command + two ignored bytes + dummy

    typedef enum logic [7:0] {
        CMD_IDENT   = 8'h01,
        CMD_LEN_WR  = 8'h02,
        CMD_STAT_WR = 8'h03,
        CMD_BUF_WR  = 8'h04,
        CMD_LEN_RD  = 8'h05,
        CMD_STAT_RD = 8'h06,
        CMD_BUF_RD  = 8'h07
    } cmd_code_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ID,
        ST_WLEN,
        ST_WSTATE,
        ST_WDATA,
        ST_RLEN,
        ST_RSTATE,
        ST_RDATA,
        ST_IGNORE
    } fsm_e;

endpackage

// File: rtl/spi_cmdbuf_sync.sv
module spi_cmdbuf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sclk_p, cs_p, mosi_p;
    logic         sclk_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= '1;
            cs_p   <= '1;
            mosi_p <= '0;
            sclk_d <= 1'b1;
        end else begin
            sclk_p <= {sclk_p[TOP-1:0], sclk_i};
            cs_p   <= {cs_p[TOP-1:0], cs_n_i};
            mosi_p <= {mosi_p[TOP-1:0], mosi_i};
            sclk_d <= sclk_p[TOP];
        end
    end

    assign sclk_rise = sclk_p[TOP] & ~sclk_d;
    assign sclk_fall = ~sclk_p[TOP] & sclk_d;
    assign cs_act    = ~cs_p[TOP];
    assign mosi_s    = mosi_p[TOP];

endmodule

// File: rtl/spi_cmdbuf_shifter.sv
module spi_cmdbuf_shifter
    import spi_cmdbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    localparam int BW = $clog2(BYTE_W);

    logic [BW-1:0]     bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic              miso_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            miso_q   <= 1'b0;
        end else if (!cs_act) begin
            bit_cnt  <= '0;
            tx_sh    <= '0;
            rx_valid <= 1'b0;
            miso_q   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sclk_rise) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BW'(BYTE_W - 1)) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sh[BYTE_W-2:0], mosi_s};
                end
            end
            if (tx_load) begin
                tx_sh <= tx_byte;
            end else if (sclk_fall) begin
                miso_q <= tx_sh[BYTE_W-1];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign miso = miso_q;

    a_r10_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (miso == 1'b0));

    a_r1_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !sclk_fall) |=> $stable(miso));

    a_r1_byte_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sclk_rise));

endmodule

// File: rtl/spi_cmdbuf_ctrl.sv
module spi_cmdbuf_ctrl
    import spi_cmdbuf_pkg::*;
#(
    parameter int          DEPTH    = 1024,
    parameter logic [7:0]  ID_VALUE = 8'h01,
    parameter bit          WRAP_EN  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte
);
    localparam int AW    = $clog2(DEPTH);
    localparam int IDX_W = $clog2(DEPTH + RD_HDR_LEN + 1) + 1;
    localparam logic [IDX_W-1:0] IDX_MAX  = '1;
    localparam logic [AW-1:0]    ADDR_TOP = AW'(DEPTH - 1);

    fsm_e              state_q, state_d;
    logic [IDX_W-1:0]  idx_q, nxt_idx;
    logic [AW-1:0]     waddr_q, raddr_q;
    logic              full_q, rd_done_q;
    logic [15:0]       len_q;
    logic [7:0]        stat_q;
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] resp;
    logic              mem_we, rd_step;

    function automatic fsm_e decode(input logic [7:0] code);
        case (code)
            CMD_IDENT:   return ST_ID;
            CMD_LEN_WR:  return ST_WLEN;
            CMD_STAT_WR: return ST_WSTATE;
            CMD_BUF_WR:  return ST_WDATA;
            CMD_LEN_RD:  return ST_RLEN;
            CMD_STAT_RD: return ST_RSTATE;
            CMD_BUF_RD:  return ST_RDATA;
            default:     return ST_IGNORE;
        endcase
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_act)   state_d = ST_CMD;
            ST_CMD:  if (rx_valid) state_d = decode(rx_byte);
            default: state_d = state_q;
        endcase
        if (!cs_act) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // reply byte for the next position in the frame
    assign nxt_idx = idx_q + 1'b1;
    always_comb begin
        resp = '0;
        unique case (state_d)
            ST_ID:     if (nxt_idx == IDX_W'(4)) resp = ID_VALUE;
            ST_RLEN: begin
                if (nxt_idx == IDX_W'(4)) resp = len_q[15:8];
                if (nxt_idx == IDX_W'(5)) resp = len_q[7:0];
            end
            ST_RSTATE: if (nxt_idx == IDX_W'(4)) resp = stat_q;
            ST_RDATA:  if (nxt_idx >= IDX_W'(RD_HDR_LEN) && !rd_done_q) resp = mem[raddr_q];
            default:   resp = '0;
        endcase
    end

    assign mem_we  = cs_act && rx_valid && (state_q == ST_WDATA) &&
                     (idx_q >= IDX_W'(WR_HDR_LEN)) && !full_q;
    assign rd_step = cs_act && rx_valid && (state_q == ST_RDATA) &&
                     (nxt_idx >= IDX_W'(RD_HDR_LEN)) && !rd_done_q;

    always_ff @(posedge clk) begin
        if (mem_we) mem[waddr_q] <= rx_byte;
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            waddr_q   <= '0;
            raddr_q   <= '0;
            full_q    <= 1'b0;
            rd_done_q <= 1'b0;
            len_q     <= '0;
            stat_q    <= '0;
            tx_byte   <= '0;
            tx_load   <= 1'b0;
        end else begin
            tx_load <= 1'b0;
            if (!cs_act) begin
                idx_q     <= '0;
                waddr_q   <= '0;
                raddr_q   <= '0;
                full_q    <= 1'b0;
                rd_done_q <= 1'b0;
            end else if (rx_valid) begin
                if (idx_q != IDX_MAX) idx_q <= nxt_idx;
                tx_load <= 1'b1;
                tx_byte <= resp;
                if (state_q == ST_WLEN && idx_q == IDX_W'(1)) len_q[15:8] <= rx_byte;
                if (state_q == ST_WLEN && idx_q == IDX_W'(2)) len_q[7:0]  <= rx_byte;
                if (state_q == ST_WSTATE && idx_q == IDX_W'(1)) stat_q <= rx_byte;
                if (mem_we) begin
                    if (waddr_q == ADDR_TOP) begin
                        waddr_q <= '0;
                        if (!WRAP_EN) full_q <= 1'b1;
                    end else begin
                        waddr_q <= waddr_q + 1'b1;
                    end
                end
                if (rd_step) begin
                    if (raddr_q == ADDR_TOP) rd_done_q <= 1'b1;
                    else                     raddr_q   <= raddr_q + 1'b1;
                end
            end
        end
    end

    a_r9_idle_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state_q == ST_IDLE));

    a_r2_cmd_decoded_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && rx_valid) |=> (state_q != ST_CMD));

    a_r11_ignore_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE && cs_act) |=> (state_q == ST_IGNORE));

    a_r11_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE && tx_load) |-> (tx_byte == '0));

    a_r6_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && cs_act) |=> full_q);

    a_r11_no_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |=> ($stable(len_q) && $stable(stat_q)));

endmodule

// File: rtl/spi_cmdbuf.sv
module spi_cmdbuf #(
    parameter int          DEPTH       = 1024,
    parameter logic [7:0]  ID_VALUE    = 8'h01,
    parameter bit          WRAP_EN     = 1'b0,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    logic       sclk_rise, sclk_fall, cs_act, mosi_s;
    logic       rx_valid, tx_load;
    logic [7:0] rx_byte, tx_byte;

    spi_cmdbuf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (spi_sclk),
        .cs_n_i    (spi_cs_n),
        .mosi_i    (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s)
    );

    spi_cmdbuf_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    spi_cmdbuf_ctrl #(
        .DEPTH    (DEPTH),
        .ID_VALUE (ID_VALUE),
        .WRAP_EN  (WRAP_EN)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte)
    );

endmodule

// File: tb/spi_cmdbuf_bench.sv
module spi_cmdbuf_bench;

    localparam int WDEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic mosi = 1'b0;
    logic cs_m = 1'b1;
    logic cs_w = 1'b1;
    logic sel = 1'b0;
    logic miso_m, miso_w, miso_sel;

    int total = 0;
    int bad = 0;

    logic [7:0] txb [0:1031];
    logic [7:0] rxb [0:1031];

    always #5 clk = ~clk;

    spi_cmdbuf u_spi_cmdbuf (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk),
        .spi_cs_n(cs_m), .spi_mosi(mosi), .spi_miso(miso_m)
    );

    spi_cmdbuf #(.DEPTH(WDEPTH), .WRAP_EN(1'b1)) u_spi_cmdbuf_wrap (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk),
        .spi_cs_n(cs_w), .spi_mosi(mosi), .spi_miso(miso_w)
    );

    assign miso_sel = sel ? miso_w : miso_m;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_tx();
        for (int k = 0; k < 1032; k++) txb[k] = 8'h00;
    endtask

    task automatic xfer_bits(input logic [7:0] t, input int nbits, output logic [7:0] r);
        r = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            sclk = 1'b0;
            mosi = t[i];
            repeat (4) @(negedge clk);
            r[i] = miso_sel;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic set_cs(input logic v);
        if (sel) cs_w = v;
        else     cs_m = v;
    endtask

    task automatic run_frame(input int n, input int gap);
        logic [7:0] r;
        set_cs(1'b0);
        repeat (4) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            xfer_bits(txb[k], 8, r);
            rxb[k] = r;
        end
        repeat (4) @(negedge clk);
        set_cs(1'b1);
        repeat (gap) @(negedge clk);
    endtask

    task automatic abort_frame(input int nfull, input int nbits);
        logic [7:0] r;
        set_cs(1'b0);
        repeat (4) @(negedge clk);
        for (int k = 0; k < nfull; k++) xfer_bits(txb[k], 8, r);
        xfer_bits(txb[nfull], nbits, r);
        set_cs(1'b1);
        repeat (6) @(negedge clk);
    endtask

    task automatic rd_len(input string req, input logic [15:0] exp, input int gap);
        clr_tx(); txb[0] = 8'h05;
        run_frame(6, gap);
        chk(req, {rxb[4], rxb[5]}, exp);
    endtask

    task automatic rd_stat(input string req, input logic [7:0] exp, input int gap);
        clr_tx(); txb[0] = 8'h06;
        run_frame(5, gap);
        chk(req, {8'h00, rxb[4]}, {8'h00, exp});
    endtask

    task automatic wr_len(input logic [15:0] v, input int gap);
        clr_tx(); txb[0] = 8'h02; txb[1] = v[15:8]; txb[2] = v[7:0];
        run_frame(3, gap);
    endtask

    task automatic wr_stat(input logic [7:0] v, input int gap);
        clr_tx(); txb[0] = 8'h03; txb[1] = v;
        run_frame(2, gap);
    endtask

    // R10, R7, R8: reset state
    task automatic t_reset();
        chk("R10 miso after reset", {15'd0, miso_m}, 16'h0000);
        rd_len("R7 length reset value", 16'h0000, 8);
        rd_stat("R8 state reset value", 8'h00, 8);
    endtask

    // R3, R1, R2, R10
    task automatic t_ident();
        clr_tx(); txb[0] = 8'h01; txb[1] = 8'hFF; txb[2] = 8'hA5; txb[3] = 8'h3C;
        run_frame(5, 2);
        chk("R3 id at byte 4", {8'h00, rxb[4]}, 16'h0001);
        chk("R3 bytes 0-3 zero", {rxb[0] | rxb[1], rxb[2] | rxb[3]}, 16'h0000);
        repeat (4) @(negedge clk);
        chk("R10 miso idle after frame", {15'd0, miso_m}, 16'h0000);
    endtask

    // R7, R8, R2
    task automatic t_regs();
        wr_len(16'hBEEF, 8);
        rd_len("R7 length readback", 16'hBEEF, 8);
        wr_stat(8'h5A, 8);
        rd_stat("R8 state readback", 8'h5A, 8);
        rd_len("R2 state write leaves length", 16'hBEEF, 8);
    endtask

    // R4, R5, R6 with the full-size buffer
    task automatic t_bulk();
        int errs;
        int first;
        clr_tx(); txb[0] = 8'h04; txb[1] = 8'h00; txb[2] = 8'h00;
        for (int i = 0; i < 1024; i++) txb[3 + i] = 8'((i * 7 + 3) & 255);
        txb[1027] = 8'hEE;
        run_frame(1028, 3);
        clr_tx(); txb[0] = 8'h07;
        run_frame(1028, 8);
        chk("R5 header bytes zero", {rxb[1] | rxb[2], rxb[3]}, 16'h0000);
        errs = 0; first = -1;
        for (int i = 0; i < 1024; i++) begin
            if (rxb[4 + i] !== 8'((i * 7 + 3) & 255)) begin
                errs++;
                if (first < 0) first = i;
            end
        end
        chk("R4 R5 buffer mismatches", 16'(errs), 16'h0000);
        if (first >= 0) $display("  first mismatch at address %0d", first);
        chk("R6 address 0 not overwritten", {8'h00, rxb[4]}, 16'h0003);
        chk("R6 last address kept", {8'h00, rxb[1027]}, {8'h00, 8'((1023 * 7 + 3) & 255)});
    endtask

    // R9: aborted frames
    task automatic t_abort();
        wr_stat(8'h33, 8);
        clr_tx(); txb[0] = 8'h03; txb[1] = 8'hC4;
        abort_frame(1, 4);
        rd_stat("R9 partial byte discarded", 8'h33, 8);
        clr_tx(); txb[0] = 8'h01;
        abort_frame(0, 5);
        clr_tx(); txb[0] = 8'h01;
        run_frame(5, 8);
        chk("R9 fresh command after abort", {8'h00, rxb[4]}, 16'h0001);
    endtask

    // R11: unknown command
    task automatic t_unknown();
        int ored;
        clr_tx(); txb[0] = 8'h09; txb[1] = 8'h12; txb[2] = 8'h34; txb[3] = 8'h56;
        run_frame(8, 8);
        ored = 0;
        for (int k = 0; k < 8; k++) ored = ored | int'(rxb[k]);
        chk("R11 miso zero for unknown", 16'(ored), 16'h0000);
        rd_len("R11 length untouched", 16'hBEEF, 8);
        rd_stat("R11 state untouched", 8'h33, 8);
    endtask

    // R12: back-to-back frames with a 3-cycle chip-select gap
    task automatic t_b2b();
        wr_len(16'h1234, 3);
        rd_len("R12 length back to back", 16'h1234, 3);
        wr_stat(8'hC7, 3);
        rd_stat("R12 state back to back", 8'hC7, 3);
        clr_tx(); txb[0] = 8'h04; txb[3] = 8'h11; txb[4] = 8'h22;
        run_frame(5, 3);
        clr_tx(); txb[0] = 8'h04; txb[3] = 8'h91; txb[4] = 8'h92;
        run_frame(5, 3);
        clr_tx(); txb[0] = 8'h07;
        run_frame(6, 8);
        chk("R12 R4 second frame data", {rxb[4], rxb[5]}, 16'h9192);
    endtask

    // R6: wrap variant
    task automatic t_wrap();
        int errs;
        logic [7:0] e;
        sel = 1'b1;
        clr_tx(); txb[0] = 8'h04;
        for (int i = 0; i < WDEPTH + 2; i++) txb[3 + i] = 8'(8'h40 + i);
        run_frame(3 + WDEPTH + 2, 8);
        clr_tx(); txb[0] = 8'h07;
        run_frame(4 + WDEPTH, 8);
        chk("R6 wrap overwrote address 0 and 1", {rxb[4], rxb[5]}, 16'h5051);
        errs = 0;
        for (int i = 2; i < WDEPTH; i++) begin
            e = 8'(8'h40 + i);
            if (rxb[4 + i] !== e) errs++;
        end
        chk("R6 wrap other addresses", 16'(errs), 16'h0000);
        sel = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_ident();
        t_regs();
        t_abort();
        t_unknown();
        t_b2b();
        t_wrap();
        t_bulk();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule